// File: doc/BRIEF.md
# Restartable Block Copy Engine

The engine copies a block of words from one region of memory to another, one word per iteration, through a single memory port. It takes three operands: where reading starts, how many words to move, and where writing starts. Each word costs one read and one write. After every write the engine counts the word as moved and advances both addresses.

After each word the engine decides whether to give way to a pending interrupt. If interrupts are enabled, it stops between words. The operand registers then hold the remaining work, so re-issuing the command with those register values resumes the copy. No word is lost or copied twice. An optional code-relative mode takes the source operand as an offset from a code base. In that case the word read is at base + 1 + offset.

Interrupts count as enabled when the wakeup-disable counter input is zero. A counter that has just returned to zero buys one more word before a yield is possible. The interrupt service itself is outside this block.

Top module: `blkmv_engine`

## Requirements
- R1: A `start_i` pulse while idle loads the operands. The engine then copies `cnt_i` words: word k is read from source address + k and written to destination address + k, for k = 0 .. count-1. No other memory location is written.
- R2: Each completed write decrements `cnt_o` by exactly 1 and increments `src_o` and `dst_o` by exactly 1. For every word, the read handshake comes before the write handshake.
- R3: When `code_rel_i` = 1 at start, word k is read from `code_base_i` + 1 + offset + k. `src_o` holds the offset, not the absolute address.
- R4: After the write that brings the count to zero, `done_o` is high for exactly one cycle, in the cycle after that write. In that cycle `cnt_o` = 0 and `busy_o` = 0.
- R5: A start with `cnt_i` = 0 raises `done_o` in the next cycle and makes no memory request.
- R6: If, at the completion of a write that is not the last one, `irq_pend_i` = 1, `wdc_i` = 0 and no grace word is owed, the engine stops. `yield_o` is high for one cycle and no further memory request follows.
- R7: While `wdc_i` is non-zero the engine never yields, whatever `irq_pend_i` does.
- R8: After `wdc_i` changes from non-zero to zero, the first write completed with `wdc_i` = 0 never yields. A yield is possible from the next write on.
- R9: Re-issuing the command with the `src_o`, `cnt_o` and `dst_o` left by a yield, and the same mode, writes every remaining word exactly once.
- R10: `start_i` is ignored while `busy_o` = 1.
- R11: While `mem_req_o` = 1 and `mem_ready_i` = 0, the request, direction, address and write data stay unchanged in the next cycle.
- R12: When the last word completes, `done_o` is raised even if an interrupt is pending and enabled. `yield_o` always leaves a non-zero count.
- R13: After reset, `busy_o`, `done_o`, `yield_o` and `mem_req_o` are 0 and the operand outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start a copy with the operands below (taken only while idle) |
| code_rel_i | input | 1 | 1: source operand is an offset from the code base |
| src_i | input | AW | First source address or offset |
| cnt_i | input | CW | Number of words to copy |
| dst_i | input | AW | First destination address |
| code_base_i | input | AW | Code base for code-relative mode |
| irq_pend_i | input | 1 | Interrupt pending |
| wdc_i | input | WDW | Wakeup-disable counter; zero means interrupts are enabled |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1: write access, 0: read access |
| mem_addr_o | output | AW | Memory address |
| mem_wdata_o | output | DW | Write data |
| mem_rdata_i | input | DW | Read data, valid with `mem_ready_i` on a read |
| mem_ready_i | input | 1 | Access completes in this cycle |
| busy_o | output | 1 | Copy in progress |
| done_o | output | 1 | One-cycle pulse: copy complete |
| yield_o | output | 1 | One-cycle pulse: stopped for an interrupt, restart needed |
| src_o | output | AW | Current source address or offset |
| cnt_o | output | CW | Words still to copy |
| dst_o | output | AW | Current destination address |

## Verification
The properties assume a memory that answers each request eventually and returns read data in the cycle it raises `mem_ready_i`. They also assume that `code_base_i` does not change during a copy, because the stability of the request address depends on it. The bench's memory model completes accesses either every cycle or every other cycle, and it holds the code base constant for the whole of each command. Source and destination regions never overlap, so the expected contents follow from the initial pattern alone.

// File: rtl/blkmv_pkg.sv
// Shared types for the restartable block copy engine.
// Assumes: nothing beyond IEEE 1800-2017 enumerations.
package blkmv_pkg;

    // Sequencer phases: waiting for a command, reading a word, writing it.
    typedef enum logic [1:0] {
        BM_IDLE  = 2'd0,
        BM_READ  = 2'd1,
        BM_WRITE = 2'd2
    } bm_state_e;

endpackage

// File: rtl/blkmv_src_addr.sv
// Source address former: turns the source operand into the read address.
// In code-relative mode the operand is an offset and the address is
// base + 1 + offset; otherwise the operand is the address itself.
// Assumes: base is stable while a copy runs.
module blkmv_src_addr #(
    parameter int AW = 16
) (
    input  logic          rel_i,
    input  logic [AW-1:0] base_i,
    input  logic [AW-1:0] off_i,
    output logic [AW-1:0] addr_o
);
    localparam logic [AW-1:0] ONE_A = AW'(1);

    // Select absolute or base-relative read address.
    always_comb begin
        if (rel_i)
            addr_o = base_i + ONE_A + off_i;
        else
            addr_o = off_i;
    end
endmodule

// File: rtl/blkmv_operands.sv
// Operand registers: source, count and destination. They load on a
// command and step once per completed word. These are the values
// software re-issues to resume after a yield.
// Assumes: load and step are never high together.
module blkmv_operands #(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic          step_i,
    input  logic [AW-1:0] src_i,
    input  logic [CW-1:0] cnt_i,
    input  logic [AW-1:0] dst_i,
    output logic [AW-1:0] src_o,
    output logic [CW-1:0] cnt_o,
    output logic [AW-1:0] dst_o,
    output logic          last_o
);
    localparam logic [AW-1:0] ONE_A = AW'(1);
    localparam logic [CW-1:0] ONE_C = CW'(1);

    logic [AW-1:0] src_r;
    logic [CW-1:0] cnt_r;
    logic [AW-1:0] dst_r;

    // Load on command, advance pointers and shrink count per word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_r <= '0;
            cnt_r <= '0;
            dst_r <= '0;
        end else if (load_i) begin
            src_r <= src_i;
            cnt_r <= cnt_i;
            dst_r <= dst_i;
        end else if (step_i) begin
            src_r <= src_r + ONE_A;
            cnt_r <= cnt_r - ONE_C;
            dst_r <= dst_r + ONE_A;
        end
    end

    assign src_o  = src_r;
    assign cnt_o  = cnt_r;
    assign dst_o  = dst_r;
    assign last_o = (cnt_r == ONE_C);
endmodule

// File: rtl/blkmv_yield_gate.sv
// Yield gate: decides at each word boundary whether a pending interrupt
// may pre-empt the copy. Interrupts are enabled when the disable counter
// is zero. A grace flag, set whenever the counter is non-zero, owes one
// word after re-enable before a yield is permitted.
// Assumes: word_done_i is a single-cycle strobe per completed write.
module blkmv_yield_gate #(
    parameter int WDW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           irq_i,
    input  logic [WDW-1:0] wdc_i,
    input  logic           word_done_i,
    output logic           yield_ok_o
);
    logic grace_r;
    logic enabled;

    assign enabled = (wdc_i == '0);

    // Track the owed grace word: armed while disabled, spent by a word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            grace_r <= 1'b0;
        else if (!enabled)
            grace_r <= 1'b1;
        else if (word_done_i)
            grace_r <= 1'b0;
    end

    assign yield_ok_o = irq_i && enabled && !grace_r;
endmodule

// File: rtl/blkmv_engine.sv
// Restartable block copy engine, top level. It sequences one read and
// one write per word over a single handshaked memory port, steps the
// operand registers after each write, then completes or yields.
// Assumes: code_base_i is constant during a copy; the memory returns
// read data in the cycle mem_ready_i is high.
module blkmv_engine #(
    parameter int AW  = 16,
    parameter int DW  = 16,
    parameter int CW  = 16,
    parameter int WDW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic           code_rel_i,
    input  logic [AW-1:0]  src_i,
    input  logic [CW-1:0]  cnt_i,
    input  logic [AW-1:0]  dst_i,
    input  logic [AW-1:0]  code_base_i,
    input  logic           irq_pend_i,
    input  logic [WDW-1:0] wdc_i,
    output logic           mem_req_o,
    output logic           mem_we_o,
    output logic [AW-1:0]  mem_addr_o,
    output logic [DW-1:0]  mem_wdata_o,
    input  logic [DW-1:0]  mem_rdata_i,
    input  logic           mem_ready_i,
    output logic           busy_o,
    output logic           done_o,
    output logic           yield_o,
    output logic [AW-1:0]  src_o,
    output logic [CW-1:0]  cnt_o,
    output logic [AW-1:0]  dst_o
);
    import blkmv_pkg::*;

    bm_state_e     state_r;
    logic          rel_r;
    logic [DW-1:0] data_r;
    logic          done_r;
    logic          yield_r;

    logic          load;
    logic          word_done;
    logic          last_word;
    logic          yield_ok;
    logic [AW-1:0] rd_addr;

    assign load      = (state_r == BM_IDLE) && start_i;
    assign word_done = (state_r == BM_WRITE) && mem_ready_i;

    blkmv_operands #(.AW(AW), .CW(CW)) u_operands (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .step_i (word_done),
        .src_i  (src_i),
        .cnt_i  (cnt_i),
        .dst_i  (dst_i),
        .src_o  (src_o),
        .cnt_o  (cnt_o),
        .dst_o  (dst_o),
        .last_o (last_word)
    );

    blkmv_src_addr #(.AW(AW)) u_src_addr (
        .rel_i  (rel_r),
        .base_i (code_base_i),
        .off_i  (src_o),
        .addr_o (rd_addr)
    );

    blkmv_yield_gate #(.WDW(WDW)) u_yield_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_i       (irq_pend_i),
        .wdc_i       (wdc_i),
        .word_done_i (word_done),
        .yield_ok_o  (yield_ok)
    );

    // Sequencer: accept command, read word, write word, then finish/yield/loop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_r <= BM_IDLE;
            rel_r   <= 1'b0;
            data_r  <= '0;
            done_r  <= 1'b0;
            yield_r <= 1'b0;
        end else begin
            done_r  <= 1'b0;
            yield_r <= 1'b0;
            unique case (state_r)
                BM_IDLE: begin
                    if (start_i) begin
                        rel_r <= code_rel_i;
                        if (cnt_i == '0)
                            done_r <= 1'b1;
                        else
                            state_r <= BM_READ;
                    end
                end
                BM_READ: begin
                    if (mem_ready_i) begin
                        data_r  <= mem_rdata_i;
                        state_r <= BM_WRITE;
                    end
                end
                BM_WRITE: begin
                    if (mem_ready_i) begin
                        if (last_word) begin
                            done_r  <= 1'b1;
                            state_r <= BM_IDLE;
                        end else if (yield_ok) begin
                            yield_r <= 1'b1;
                            state_r <= BM_IDLE;
                        end else begin
                            state_r <= BM_READ;
                        end
                    end
                end
                default: state_r <= BM_IDLE;
            endcase
        end
    end

    // Memory port: read from the formed source address, write to destination.
    always_comb begin
        mem_req_o   = (state_r != BM_IDLE);
        mem_we_o    = (state_r == BM_WRITE);
        mem_addr_o  = (state_r == BM_WRITE) ? dst_o : rd_addr;
        mem_wdata_o = data_r;
    end

    assign busy_o  = (state_r != BM_IDLE);
    assign done_o  = done_r;
    assign yield_o = yield_r;
endmodule

// File: rtl/blkmv_engine_chk.sv
// Property checker for the block copy engine, bound to every instance.
// Assumes: code_base_i stable during a copy (see R11 property).
module blkmv_engine_chk #(
    parameter int AW  = 16,
    parameter int DW  = 16,
    parameter int CW  = 16,
    parameter int WDW = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start_i,
    input logic [CW-1:0]  cnt_i,
    input logic           irq_pend_i,
    input logic [WDW-1:0] wdc_i,
    input logic           mem_req_o,
    input logic           mem_we_o,
    input logic [AW-1:0]  mem_addr_o,
    input logic [DW-1:0]  mem_wdata_o,
    input logic           mem_ready_i,
    input logic           busy_o,
    input logic           done_o,
    input logic           yield_o,
    input logic [AW-1:0]  src_o,
    input logic [CW-1:0]  cnt_o,
    input logic [AW-1:0]  dst_o
);
    localparam logic [AW-1:0] ONE_A = AW'(1);
    localparam logic [CW-1:0] ONE_C = CW'(1);

    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_we_o && mem_ready_i) |=>
            (cnt_o == $past(cnt_o) - ONE_C) && (src_o == $past(src_o) + ONE_A)
            && (dst_o == $past(dst_o) + ONE_A));

    p_done_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (cnt_o == '0) && !busy_o);

    p_zero_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && cnt_i == '0) |=> done_o && !mem_req_o);

    p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !mem_req_o);

    p_yield_enabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
        yield_o |-> ($past(wdc_i) == '0) && $past(irq_pend_i));

    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ready_i) |=>
            mem_req_o && $stable(mem_we_o) && $stable(mem_addr_o) && $stable(mem_wdata_o));

    p_yield_left_r12: assert property (@(posedge clk) disable iff (!rst_n)
        yield_o |-> (cnt_o != '0) && !done_o);
endmodule

bind blkmv_engine blkmv_engine_chk #(.AW(AW), .DW(DW), .CW(CW), .WDW(WDW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .cnt_i       (cnt_i),
    .irq_pend_i  (irq_pend_i),
    .wdc_i       (wdc_i),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_ready_i (mem_ready_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .yield_o     (yield_o),
    .src_o       (src_o),
    .cnt_o       (cnt_o),
    .dst_o       (dst_o)
);

// File: tb/blkmv_engine_bench.sv
// Self-checking bench: a 256-word memory model, a table of copy commands,
// then directed tests for reset, zero count, yield/restart, disable,
// grace word, last-word precedence and start while busy.
module blkmv_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        code_rel_i = 1'b0;
    logic [15:0] src_i = '0, cnt_i = '0, dst_i = '0, code_base_i = '0;
    logic        irq_pend_i = 1'b0;
    logic [7:0]  wdc_i = '0;
    logic        mem_req_o, mem_we_o, mem_ready_i;
    logic [15:0] mem_addr_o, mem_wdata_o, mem_rdata_i;
    logic        busy_o, done_o, yield_o;
    logic [15:0] src_o, cnt_o, dst_o;

    logic [15:0] mem [256];
    int unsigned wr_cnt = 0;
    logic        slow = 1'b0;
    logic        rdy_q = 1'b1;
    int          n_chk = 0;
    int          n_bad = 0;

    always #4 clk = ~clk;

    blkmv_engine u_blkmv_engine (.*);

    // Memory model: combinational read, write on a completed write request.
    assign mem_rdata_i = mem[mem_addr_o[7:0]];
    assign mem_ready_i = slow ? rdy_q : 1'b1;
    always @(negedge clk) rdy_q <= ~rdy_q;
    always @(posedge clk) begin
        if (mem_req_o && mem_we_o && mem_ready_i) begin
            mem[mem_addr_o[7:0]] <= mem_wdata_o;
            wr_cnt <= wr_cnt + 1;
        end
    end

    typedef struct packed {
        logic [15:0] src;
        logic [15:0] cnt;
        logic [15:0] dst;
        logic [15:0] base;
        logic        rel;
        logic        slw;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{16'h0010, 16'd4,  16'h0080, 16'h0000, 1'b0, 1'b0},
        '{16'h0020, 16'd1,  16'h0090, 16'h0000, 1'b0, 1'b1},
        '{16'h0005, 16'd9,  16'h00A0, 16'h0030, 1'b1, 1'b0},
        '{16'h0040, 16'd16, 16'h00C0, 16'h0000, 1'b0, 1'b1},
        '{16'h0000, 16'd3,  16'h0060, 16'h0050, 1'b1, 1'b1},
        '{16'h0070, 16'd7,  16'h0008, 16'h0000, 1'b0, 1'b0}
    };

    function automatic logic [15:0] pat(input int a);
        return 16'hB000 + 16'(a * 7);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic init_mem();
        for (int i = 0; i < 256; i++) mem[i] = pat(i);
    endtask

    // Issue one command and wait until it completes or yields.
    task automatic issue(input logic [15:0] s, input logic [15:0] c, input logic [15:0] d,
                         input logic rel, input logic [15:0] b);
        @(negedge clk);
        src_i = s; cnt_i = c; dst_i = d; code_rel_i = rel; code_base_i = b;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        while (!(done_o || yield_o)) @(negedge clk);
    endtask

    // Check that words [d, d+c) hold the source pattern starting at sa.
    task automatic chk_copy(input int sa, input int d, input int c, input string tag);
        int bad = 0;
        int first = 0;
        for (int k = 0; k < c; k++) begin
            if (mem[(d + k) % 256] !== pat(sa + k)) begin
                if (bad == 0) first = k;
                bad++;
            end
        end
        chk(bad == 0, tag, 32'(mem[(d + first) % 256]), 32'(pat(sa + first)));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        int unsigned w0;
        int sa;
        int ylds;
        init_mem();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13: reset state
        chk(!busy_o && !done_o && !yield_o && !mem_req_o, "R13 idle flags", {busy_o, done_o, yield_o, mem_req_o}, 0);
        chk(src_o == 0 && cnt_o == 0 && dst_o == 0, "R13 operands", 32'(cnt_o), 0);

        // R1 R2 R3 R4: table of commands
        foreach (VECS[v]) begin
            init_mem();
            slow = VECS[v].slw;
            w0 = wr_cnt;
            sa = VECS[v].rel ? int'(VECS[v].base) + 1 + int'(VECS[v].src) : int'(VECS[v].src);
            issue(VECS[v].src, VECS[v].cnt, VECS[v].dst, VECS[v].rel, VECS[v].base);
            chk(done_o && !busy_o && cnt_o == 0, "R4 done with zero count", 32'(cnt_o), 0);
            chk_copy(sa, int'(VECS[v].dst), int'(VECS[v].cnt), "R1 R3 copied data");
            chk(wr_cnt - w0 == VECS[v].cnt, "R1 write count", wr_cnt - w0, 32'(VECS[v].cnt));
            chk(src_o == VECS[v].src + VECS[v].cnt && dst_o == VECS[v].dst + VECS[v].cnt,
                "R2 pointers advanced", {src_o, dst_o}, {VECS[v].src + VECS[v].cnt, VECS[v].dst + VECS[v].cnt});
            chk(mem[(VECS[v].dst + VECS[v].cnt) % 256] == pat(int'(VECS[v].dst + VECS[v].cnt)),
                "R1 word past end untouched", 32'(mem[(VECS[v].dst + VECS[v].cnt) % 256]),
                32'(pat(int'(VECS[v].dst + VECS[v].cnt))));
            @(negedge clk);
            chk(!done_o, "R4 done lasts one cycle", 32'(done_o), 0);
        end

        // R5: zero count
        slow = 1'b0;
        w0 = wr_cnt;
        issue(16'h0010, 16'd0, 16'h0080, 1'b0, 16'h0);
        chk(done_o && !mem_req_o, "R5 zero count done", {done_o, mem_req_o}, 2'b10);
        chk(wr_cnt == w0, "R5 no writes", wr_cnt - w0, 0);

        // R6 R9 R3: yield after each word in code-relative mode, then restart
        init_mem();
        slow = 1'b1;
        irq_pend_i = 1'b1;
        wdc_i = 8'd0;
        w0 = wr_cnt;
        issue(16'h0002, 16'd5, 16'h0080, 1'b1, 16'h0030);
        chk(yield_o && !busy_o && cnt_o == 4, "R6 yield after first word", 32'(cnt_o), 4);
        chk(src_o == 16'h0003 && dst_o == 16'h0081, "R3 offset held on yield", {src_o, dst_o}, {16'h0003, 16'h0081});
        chk(wr_cnt - w0 == 1, "R6 one word then stop", wr_cnt - w0, 1);
        repeat (3) @(negedge clk);
        chk(wr_cnt - w0 == 1 && !mem_req_o, "R6 no access after yield", wr_cnt - w0, 1);
        ylds = 1;
        while (!done_o && ylds < 20) begin
            issue(src_o, cnt_o, dst_o, 1'b1, 16'h0030);
            if (yield_o) ylds++;
        end
        chk(done_o && ylds == 4, "R12 yields then done on last word", ylds, 4);
        chk(wr_cnt - w0 == 5, "R9 no lost or duplicated word", wr_cnt - w0, 5);
        chk_copy(16'h0033, 16'h0080, 5, "R9 resumed data");

        // R7: disabled interrupts never yield
        init_mem();
        wdc_i = 8'd3;
        w0 = wr_cnt;
        issue(16'h0010, 16'd4, 16'h0090, 1'b0, 16'h0);
        chk(done_o && !yield_o && wr_cnt - w0 == 4, "R7 no yield while disabled", wr_cnt - w0, 4);

        // R12: single word with enabled pending interrupt completes
        wdc_i = 8'd0;
        repeat (2) @(negedge clk);
        issue(16'h0020, 16'd1, 16'h00A0, 1'b0, 16'h0);
        chk(done_o && !yield_o, "R12 last word completes", {done_o, yield_o}, 2'b10);

        // R8: grace word after re-enable
        init_mem();
        wdc_i = 8'd1;
        slow = 1'b0;
        w0 = wr_cnt;
        @(negedge clk);
        src_i = 16'h0010; cnt_i = 16'd6; dst_i = 16'h00B0; code_rel_i = 1'b0;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        while (wr_cnt - w0 < 2) @(negedge clk);
        wdc_i = 8'd0;
        while (!(done_o || yield_o)) @(negedge clk);
        chk(yield_o && cnt_o == 2, "R8 grace word before yield", 32'(cnt_o), 2);
        chk(wr_cnt - w0 == 4, "R8 words before yield", wr_cnt - w0, 4);

        // R10: start while busy is ignored
        init_mem();
        irq_pend_i = 1'b0;
        slow = 1'b1;
        w0 = wr_cnt;
        @(negedge clk);
        src_i = 16'h0010; cnt_i = 16'd8; dst_i = 16'h0080; code_rel_i = 1'b0;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (3) @(negedge clk);
        src_i = 16'h0040; cnt_i = 16'd2; dst_i = 16'h00E0;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        while (!(done_o || yield_o)) @(negedge clk);
        chk(done_o && dst_o == 16'h0088 && wr_cnt - w0 == 8, "R10 busy start ignored", wr_cnt - w0, 8);
        chk(mem[8'hE0] == pat(16'hE0), "R10 second region untouched", 32'(mem[8'hE0]), 32'(pat(16'hE0)));
        chk_copy(16'h0010, 16'h0080, 8, "R10 first command data");

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule